// File: doc/BRIEF.md
# Bit-Serial Accumulator Processor

This block is a very small processor whose whole internal datapath is one bit wide. Its state is a program counter, an instruction register, an address register and one accumulator, all 8 bits wide. Every transfer into these registers passes, one bit per clock and least significant bit first, through a single 1-bit ALU with one carry flip-flop. That ALU also advances the program counter; no separate incrementer exists. A 1-bit serial path reaches an 8-bit parallel memory port. On reads, a bit selector picks one bit of the read byte. Writes go through a small serial-to-parallel register.

Each instruction is two bytes: an opcode byte followed by an address byte. The processor spends a fixed 40 clocks on each instruction. These clocks form five phases of 8 bit-clocks each: fetch opcode, advance PC, fetch address, advance PC, execute. Memory reads are combinational from the port's point of view. The address stays stable for a whole phase, and a write is a single-clock strobe.

Top module: `serial_acc_cpu`

## Requirements
- R1: While `rst` is high, and after it is released, PC, IR, AR and the accumulator are zero. `mem_we` is low and `mem_addr` is 0.
- R2: Instruction k after reset release (straight-line code) occupies clocks 40k to 40k+39. The opcode is read at PC during clocks 40k..40k+7. The address byte is read at PC+1 during 40k+16..40k+23. During execute, 40k+32..40k+39, `mem_addr` shows the address byte. `mem_addr` is stable within a fetch or execute phase.
- R3: The PC advances serially with a carry and wraps from 0xFF to 0x00. An instruction at 0xFE fetches its address byte from 0xFF, and the next opcode comes from 0x00.
- R4: Opcode low bits 000 (LOAD) set the accumulator to mem[A].
- R5: Opcode low bits 001 (ADD) set the accumulator to (acc + mem[A]) mod 256. The carry starts at zero for every word, so no carry from an earlier operation leaks in.
- R6: Opcode low bits 010 (NAND) set the accumulator to ~(acc & mem[A]).
- R7: Opcode low bits 011 (STORE) write the accumulator to address A. `mem_we` is high for exactly one clock, clock 40k+39, and the accumulator is unchanged.
- R8: Opcode low bits 100 (SHR) shift the accumulator right by one, and bit 7 becomes 0. The address byte is ignored.
- R9: Opcode low bits 101 (JZ): if the accumulator is zero, the next instruction is fetched from A. Otherwise execution continues at the following instruction. The accumulator is unchanged.
- R10: Opcode low bits 110 and 111 do nothing. Opcode bits 7..3 are ignored for every operation.
- R11: `mem_we` is never raised except by STORE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory address: PC during fetch and step phases, AR during execute |
| mem_rdata | input | 8 | Memory read data for `mem_addr`, combinational |
| mem_wdata | output | 8 | Write data, valid while `mem_we` is high |
| mem_we | output | 1 | One-clock write strobe, memory writes on the rising edge |

## Verification
Counting clocks from reset release:
- A store for dynamic instruction k must appear at clock 40k+39.
- The opcode address is due at clock 40k.
- The address-byte location is due at 40k+16.
- The operand address is due at 40k+32.

For each program the driver pushes the expected store cycle, address and data into a queue. A falling-edge monitor pops one entry per observed write strobe and compares all three against the bench's clock counter, so an early, late, missing or extra write is caught. Jump and wrap behaviour is checked by sampling `mem_addr` at the exact clock an opcode fetch begins.

// File: rtl/sacc_pkg.sv
package sacc_pkg;

    // Low opcode bits that select the operation; the rest are ignored.
    localparam int unsigned OPC_BITS = 3;

    // Shift registers on the serial bus, indexed in the register array.
    localparam int unsigned NREG    = 5;
    localparam int unsigned REG_PC  = 0;
    localparam int unsigned REG_IR  = 1;
    localparam int unsigned REG_AR  = 2;
    localparam int unsigned REG_ACC = 3;
    localparam int unsigned REG_WSR = 4;

    typedef enum logic [2:0] {
        ST_OPC   = 3'd0,
        ST_STEP1 = 3'd1,
        ST_ARG   = 3'd2,
        ST_STEP2 = 3'd3,
        ST_RUN   = 3'd4
    } phase_e;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_ADD   = 3'd1,
        OP_NAND  = 3'd2,
        OP_STORE = 3'd3,
        OP_SHR   = 3'd4,
        OP_JZ    = 3'd5,
        OP_NOP6  = 3'd6,
        OP_NOP7  = 3'd7
    } opc_e;

    typedef enum logic [2:0] {
        ALU_PASS_A = 3'd0,
        ALU_PASS_B = 3'd1,
        ALU_ADD    = 3'd2,
        ALU_NAND   = 3'd3,
        ALU_INC    = 3'd4
    } alu_e;

    // Per-clock control word of the serial datapath.
    typedef struct packed {
        alu_e            op;
        logic            a;
        logic            b;
        logic [NREG-1:0] en;
        logic            we;
    } ctl_t;

    function automatic phase_e phase_after(input phase_e p);
        case (p)
            ST_OPC:   return ST_STEP1;
            ST_STEP1: return ST_ARG;
            ST_ARG:   return ST_STEP2;
            ST_STEP2: return ST_RUN;
            default:  return ST_OPC;
        endcase
    endfunction

endpackage

// File: rtl/sacc_seq.sv
module sacc_seq
    import sacc_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    output phase_e        phase,
    output logic [CW-1:0] bitn,
    output logic          first,
    output logic          last
);
    localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);

    assign first = (bitn == '0);
    assign last  = (bitn == LAST_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= ST_OPC;
            bitn  <= '0;
        end else begin
            bitn <= last ? '0 : bitn + 1'b1;
            if (last) begin
                phase <= phase_after(phase);
            end
        end
    end

    // R2: a phase is never left before its final bit-clock
    p_phase_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !last |=> $stable(phase));

endmodule

// File: rtl/sacc_alu.sv
module sacc_alu
    import sacc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic first,
    input  alu_e op,
    input  logic a,
    input  logic b,
    output logic y
);
    logic carry_q;
    logic cin;
    logic cnext;

    always_comb begin
        // Word start: carry-in is 1 for increment, 0 otherwise.
        cin   = first ? (op == ALU_INC) : carry_q;
        y     = 1'b0;
        cnext = 1'b0;
        unique case (op)
            ALU_PASS_A: y = a;
            ALU_PASS_B: y = b;
            ALU_ADD: begin
                y     = a ^ b ^ cin;
                cnext = (a & b) | (cin & (a ^ b));
            end
            ALU_NAND: y = ~(a & b);
            ALU_INC: begin
                y     = a ^ cin;
                cnext = a & cin;
            end
            default: y = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= 1'b0;
        end else if (en) begin
            carry_q <= cnext;
        end
    end

endmodule

// File: rtl/sacc_sreg.sv
module sacc_sreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         sin,
    output logic [W-1:0] q
);
    // Right shift: new bit enters at the top, LSB leaves first.
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= {sin, q[W-1:1]};
        end
    end

endmodule

// File: rtl/serial_acc_cpu.sv
module serial_acc_cpu
    import sacc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] mem_addr,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] mem_wdata,
    output logic         mem_we
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    phase_e        phase;
    logic [CW-1:0] bitn;
    logic          first;
    logic          last;
    ctl_t          ctl;
    logic          alu_y;
    logic [W-1:0]  regs [NREG];
    logic [W-1:0]  pc, ir, ar, acc, wsr;
    opc_e          opc;
    logic          rbit;
    logic          acc_zero;
    logic          unused_bits;

    sacc_seq #(.W(W), .CW(CW)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .bitn  (bitn),
        .first (first),
        .last  (last)
    );

    sacc_alu u_alu (
        .clk   (clk),
        .rst   (rst),
        .en    (|ctl.en),
        .first (first),
        .op    (ctl.op),
        .a     (ctl.a),
        .b     (ctl.b),
        .y     (alu_y)
    );

    // Every register is a right-shift register fed by the ALU output.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        sacc_sreg #(.W(W)) u_reg (
            .clk (clk),
            .rst (rst),
            .en  (ctl.en[g]),
            .sin (alu_y),
            .q   (regs[g])
        );
    end

    assign pc  = regs[REG_PC];
    assign ir  = regs[REG_IR];
    assign ar  = regs[REG_AR];
    assign acc = regs[REG_ACC];
    assign wsr = regs[REG_WSR];

    assign opc         = opc_e'(ir[OPC_BITS-1:0]);
    assign rbit        = mem_rdata[bitn];
    assign acc_zero    = (acc == '0);
    assign unused_bits = ^{ir[W-1:OPC_BITS], wsr[0]};

    always_comb begin
        ctl    = '0;
        ctl.op = ALU_PASS_B;
        unique case (phase)
            ST_OPC: begin
                ctl.b           = rbit;
                ctl.en[REG_IR]  = 1'b1;
            end
            ST_STEP1, ST_STEP2: begin
                ctl.op          = ALU_INC;
                ctl.a           = pc[0];
                ctl.en[REG_PC]  = 1'b1;
            end
            ST_ARG: begin
                ctl.b           = rbit;
                ctl.en[REG_AR]  = 1'b1;
            end
            ST_RUN: begin
                unique case (opc)
                    OP_LOAD: begin
                        ctl.b            = rbit;
                        ctl.en[REG_ACC]  = 1'b1;
                    end
                    OP_ADD: begin
                        ctl.op           = ALU_ADD;
                        ctl.a            = acc[0];
                        ctl.b            = rbit;
                        ctl.en[REG_ACC]  = 1'b1;
                    end
                    OP_NAND: begin
                        ctl.op           = ALU_NAND;
                        ctl.a            = acc[0];
                        ctl.b            = rbit;
                        ctl.en[REG_ACC]  = 1'b1;
                    end
                    OP_STORE: begin
                        // Accumulator rotates through the ALU into the
                        // write converter; strobe on the final bit.
                        ctl.op           = ALU_PASS_A;
                        ctl.a            = acc[0];
                        ctl.en[REG_ACC]  = 1'b1;
                        ctl.en[REG_WSR]  = 1'b1;
                        ctl.we           = last;
                    end
                    OP_SHR: begin
                        // Serial output of the next bit feeds back; a zero
                        // enters as the new top bit.
                        ctl.op           = ALU_PASS_A;
                        ctl.a            = last ? 1'b0 : acc[1];
                        ctl.en[REG_ACC]  = 1'b1;
                    end
                    OP_JZ: begin
                        if (acc_zero) begin
                            ctl.b           = ar[bitn];
                            ctl.en[REG_PC]  = 1'b1;
                        end
                    end
                    default: ctl.op = ALU_PASS_B;
                endcase
            end
            default: ctl.op = ALU_PASS_B;
        endcase
    end

    assign mem_addr  = (phase == ST_RUN) ? ar : pc;
    assign mem_wdata = {alu_y, wsr[W-1:1]};
    assign mem_we    = ctl.we;

    // ---------------------------------------------------------------
    // Checking support: register values at the start of each phase.
    // ---------------------------------------------------------------
    logic [W-1:0] snap_pc;
    logic [W-1:0] snap_acc;
    logic         snap_z;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_pc  <= '0;
            snap_acc <= '0;
            snap_z   <= 1'b0;
        end else if (first) begin
            snap_pc  <= pc;
            snap_acc <= acc;
            snap_z   <= acc_zero;
        end
    end

    // R3: a step phase leaves PC one higher, modulo the width
    p_pc_step_r3: assert property (@(posedge clk) disable iff (rst)
        (last && (phase == ST_STEP1 || phase == ST_STEP2)) |=> (pc == snap_pc + 1'b1));

    // R9: jump loads AR only when the accumulator was zero
    p_jz_target_r9: assert property (@(posedge clk) disable iff (rst)
        (last && phase == ST_RUN && opc == OP_JZ) |=> (pc == (snap_z ? ar : snap_pc)));

    // R7: store, jump and no-op leave the accumulator as it was
    p_acc_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (last && phase == ST_RUN &&
         (opc == OP_STORE || opc == OP_JZ || opc == OP_NOP6 || opc == OP_NOP7))
        |=> (acc == snap_acc));

    // R8: right shift by one with a zero at the top
    p_shr_result_r8: assert property (@(posedge clk) disable iff (rst)
        (last && phase == ST_RUN && opc == OP_SHR)
        |=> (acc[W-1] == 1'b0 && acc[W-2:0] == snap_acc[W-1:1]));

    // R7: the write strobe lasts one clock
    p_we_once_r7: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R2: address held steady inside fetch and execute phases
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!first && phase != ST_STEP1 && phase != ST_STEP2) |-> $stable(mem_addr));

endmodule

// File: tb/test_serial_acc_cpu.sv
module test_serial_acc_cpu;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_addr;
    logic [7:0] mem_rdata;
    logic [7:0] mem_wdata;
    logic       mem_we;
    logic [7:0] mem [256];
    int         cyc;
    int         n_checks = 0;
    int         n_errors = 0;
    bit         done = 1'b0;

    typedef struct {
        int         at;
        logic [7:0] addr;
        logic [7:0] data;
        string      tag;
    } store_t;

    store_t sb[$];

    serial_acc_cpu #(.W(8)) i_serial_acc_cpu (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we)
    );

    always #10ns clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    function automatic void check(input string tag, input string what,
                                  input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endfunction

    // Monitor: each write strobe must match the oldest expected store.
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (sb.size() == 0) begin
                check("R11", "unexpected write strobe", 32'd1, 32'd0);
            end else begin
                store_t e;
                e = sb.pop_front();
                check(e.tag, "store cycle", 32'(cyc), 32'(e.at));
                check(e.tag, "store address", 32'(mem_addr), 32'(e.addr));
                check(e.tag, "store data", 32'(mem_wdata), 32'(e.data));
            end
        end
    end

    task automatic fill(input logic [7:0] v);
        for (int i = 0; i < 256; i++) mem[i] = v;
    endtask

    task automatic put(input int a, input logic [7:0] op, input logic [7:0] arg);
        mem[a]           = op;
        mem[(a + 1) % 256] = arg;
    endtask

    task automatic want_store(input int k, input logic [7:0] a,
                              input logic [7:0] d, input string tag);
        store_t e;
        e.at   = 40 * k + 39;
        e.addr = a;
        e.data = d;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic addr_at(input int c, input logic [7:0] e, input string tag);
        wait_cyc(c);
        check(tag, "mem_addr", 32'(mem_addr), 32'(e));
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic release_reset();
        check("R1", "mem_addr in reset", 32'(mem_addr), 32'h0);
        check("R1", "mem_we in reset", 32'(mem_we), 32'h0);
        rst = 1'b0;
        check("R1", "mem_addr after release", 32'(mem_addr), 32'h0);
    endtask

    initial begin
        // ---------------- Program 1: ALU, store, jump, no-op ----------
        hold_reset();
        fill(8'hFF);                       // 0xFF = no-op everywhere else
        put(8'h00, 8'h00, 8'h80);          // k0  LOAD  [80]=35
        put(8'h02, 8'h01, 8'h81);          // k1  ADD   [81]=4C -> 81
        put(8'h04, 8'h03, 8'h90);          // k2  STORE 81
        put(8'h06, 8'h01, 8'h82);          // k3  ADD   [82]=FF -> 80
        put(8'h08, 8'h03, 8'h91);          // k4  STORE 80
        put(8'h0A, 8'h02, 8'h83);          // k5  NAND  [83]=F0 -> 7F
        put(8'h0C, 8'h03, 8'h92);          // k6  STORE 7F
        put(8'h0E, 8'h04, 8'h90);          // k7  SHR -> 3F
        put(8'h10, 8'h03, 8'h93);          // k8  STORE 3F
        put(8'h12, 8'h01, 8'h84);          // k9  ADD   [84]=01 -> 40
        put(8'h14, 8'h03, 8'h94);          // k10 STORE 40
        put(8'h16, 8'h05, 8'h40);          // k11 JZ not taken
        put(8'h18, 8'h00, 8'h85);          // k12 LOAD  [85]=00
        put(8'h1A, 8'h05, 8'h30);          // k13 JZ taken -> 30
        put(8'h1C, 8'h03, 8'h95);          // skipped
        put(8'h30, 8'h03, 8'h96);          // k14 STORE 00
        put(8'h32, 8'h00, 8'h86);          // k15 LOAD  [86]=A5
        put(8'h34, 8'hFE, 8'h84);          // k16 no-op (low bits 110)
        put(8'h36, 8'hFF, 8'h84);          // k17 no-op (low bits 111)
        put(8'h38, 8'h03, 8'h97);          // k18 STORE A5
        put(8'h3A, 8'hF9, 8'h84);          // k19 ADD with high bits set -> A6
        put(8'h3C, 8'h03, 8'h98);          // k20 STORE A6
        mem[8'h80] = 8'h35; mem[8'h81] = 8'h4C; mem[8'h82] = 8'hFF;
        mem[8'h83] = 8'hF0; mem[8'h84] = 8'h01; mem[8'h85] = 8'h00;
        mem[8'h86] = 8'hA5; mem[8'h95] = 8'hEE;
        want_store(2,  8'h90, 8'h81, "R5");
        want_store(4,  8'h91, 8'h80, "R5");
        want_store(6,  8'h92, 8'h7F, "R6");
        want_store(8,  8'h93, 8'h3F, "R8");
        want_store(10, 8'h94, 8'h40, "R5");
        want_store(14, 8'h96, 8'h00, "R4");
        want_store(18, 8'h97, 8'hA5, "R10");
        want_store(20, 8'h98, 8'hA6, "R10");
        release_reset();

        addr_at(16,  8'h01, "R2");         // address byte at PC+1
        addr_at(32,  8'h80, "R2");         // operand address in execute
        addr_at(40,  8'h02, "R2");         // next opcode
        addr_at(480, 8'h18, "R9");         // JZ not taken falls through
        addr_at(560, 8'h30, "R9");         // JZ taken lands on target
        wait_cyc(1000);
        check("R7", "stores still pending", 32'(sb.size()), 32'd0);
        check("R9", "skipped store location", 32'(mem[8'h95]), 32'hEE);
        check("R8", "SHR operand byte untouched", 32'(mem[8'h90]), 32'h81);

        // ---------------- Program 2: reset, PC wrap ------------------
        hold_reset();
        fill(8'hFF);
        put(8'h00, 8'h05, 8'hFC);          // k0 JZ taken (acc cleared) ; k3 not taken
        put(8'hFC, 8'h00, 8'h10);          // k1 LOAD [10]=5A
        put(8'hFE, 8'h03, 8'h11);          // k2 STORE 5A
        put(8'h02, 8'h03, 8'h12);          // k4 STORE 5A
        put(8'h04, 8'h00, 8'h13);          // k5 LOAD [13]=00
        put(8'h06, 8'h05, 8'h06);          // k6 JZ to itself
        mem[8'h10] = 8'h5A; mem[8'h13] = 8'h00;
        want_store(2, 8'h11, 8'h5A, "R3");
        want_store(4, 8'h12, 8'h5A, "R9");
        release_reset();

        addr_at(40,  8'hFC, "R1");         // reset cleared acc so JZ taken
        addr_at(96,  8'hFF, "R3");         // address byte of 0xFE instruction
        addr_at(120, 8'h00, "R3");         // wrap to 0x00
        addr_at(240, 8'h06, "R9");         // JZ not taken after load 5A
        wait_cyc(400);
        check("R11", "stores still pending", 32'(sb.size()), 32'd0);

        hold_reset();
        check("R1", "mem_addr in mid-run reset", 32'(mem_addr), 32'h0);
        check("R1", "mem_we in mid-run reset", 32'(mem_we), 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL R2 watchdog: actual still running at cycle %0d expected finish", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule